// File: doc/BRIEF.md
# Sector Load and Program Sequencer

This block gathers byte writes into a one-sector staging buffer and then commits the whole sector to a backing byte array in a single timed program cycle. Each write carries a 17-bit address and a data byte. Bits 16..7 of the address name the sector and bits 6..0 name the byte within it. The first write of a sequence locks the sector. Later writes may arrive in any order and may overwrite bytes that are already loaded. Loading ends when no write arrives for a set number of timebase ticks.

The program cycle then sweeps all 128 offsets of the locked sector into the array, one per clock. A byte that was loaded is written with its buffered value. A byte that was never loaded is written as FFh. The cycle then holds busy until the program timer expires. Time is counted in ticks of an external timebase (`tick`), so the timeouts scale with the tick rate. Defaults assume a 1 µs tick: a 300-tick load gap and a 10,000-tick program cycle.

The write interface is valid/ready. `wr_ready` is high in idle and while loading, and low for the whole program cycle. A write is accepted on a clock where `wr_valid` and `wr_ready` are both high. A source that removes its write while ready is low has that write discarded. The source may not assume the write will be taken later. The backing array is a register file that holds 2^ARR_SECT_W sectors, selected by the low bits of the sector address. Its read port exists so the stored contents can be observed.

Top module: `sector_load_seq`

## Requirements
- R1: After reset, `busy` is 0, `wr_ready` is 1, `arr_we` is 0 and every array byte reads FFh.
- R2: The sector address (`wr_addr[16:7]`) is captured on the first accepted write of a sequence and shown on `sector_addr`. Upper address bits of later writes in the same sequence are ignored, and those bytes land in the captured sector.
- R3: Bytes may be loaded in any order. A byte written more than once in one sequence is committed with its most recent value.
- R4: On the clock after each accepted write, `last_idx` equals that write's offset (`wr_addr[6:0]`).
- R5: Loading continues while each write arrives within LOAD_TICKS ticks of the previous one. A write on the same clock as a tick restarts the gap count. The LOAD_TICKS-th tick with no write ends loading, and `busy` is high after that clock edge.
- R6: A program cycle writes every one of the 128 offsets of the sector. Loaded bytes get their buffered value and unloaded bytes get FFh, replacing whatever the array held there.
- R7: `wr_ready` is 0 while `busy` is 1. A write offered during the program cycle is not accepted and does not reach the array. `busy` falls after the PROG_TICKS-th tick counted from the clock on which it rose, provided the 128-clock sweep has finished by then.
- R8: A program cycle leaves the contents of every other sector unchanged.
- R9: `arr_we` is high only while `busy` is high. Its writes target the latched sector and advance through the offsets in ascending order, one per clock, starting at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse, one clock wide |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write can be accepted (low during program cycle) |
| wr_addr | input | ADDR_W (17) | Byte address: sector in high bits, offset in low 7 |
| wr_data | input | DATA_W (8) | Byte to load |
| busy | output | 1 | Program cycle in progress |
| sector_addr | output | ADDR_W-OFFS_W (10) | Latched sector of the current/last sequence |
| last_idx | output | OFFS_W (7) | Offset of the most recently accepted byte |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W (17) | Array write address |
| arr_wdata | output | DATA_W (8) | Array write data |
| rd_addr | input | ARR_SECT_W+OFFS_W (10) | Array read address |
| rd_data | output | DATA_W (8) | Array read data (combinational) |

## Verification
The bench builds the block with LOAD_TICKS=4, PROG_TICKS=100 and ARR_SECT_W=3, and drives a tick every second clock. With these values, both the load-gap timeout and the end of the program timer can be counted tick by tick in a few hundred clocks. The program window stays longer than the 128-clock sweep, so the bench can predict exactly when busy falls. The 1024-byte array holds sectors 1, 3 and 6 as separate storage, so a write that leaks into a neighbouring sector shows up, and so does an upper address bit that wrongly steers a byte.

// File: rtl/sector_load_seq_pkg.sv
package sector_load_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sls_ctrl.sv
module sls_ctrl
  import sector_load_seq_pkg::*;
#(
  parameter int OFFS_W     = 7,
  parameter int LOAD_TICKS = 300,
  parameter int PROG_TICKS = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              accept,
  output seq_state_t        state,
  output logic              sweep_we,
  output logic [OFFS_W-1:0] sweep_idx
);
  localparam int GAP_W = $clog2(LOAD_TICKS + 1);
  localparam int PRG_W = $clog2(PROG_TICKS + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(LOAD_TICKS - 1);
  localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_TICKS - 1);
  localparam logic [PRG_W-1:0] PRG_FULL = PRG_W'(PROG_TICKS);

  logic [GAP_W-1:0] gap_cnt;
  logic [PRG_W-1:0] prg_cnt;
  logic [OFFS_W:0]  sweep_cnt;
  logic             sweep_done;
  logic             timer_hit;

  assign sweep_done = sweep_cnt[OFFS_W];
  assign sweep_we   = (state == ST_PROG) && !sweep_done;
  assign sweep_idx  = sweep_cnt[OFFS_W-1:0];
  assign timer_hit  = (prg_cnt == PRG_FULL) || (tick && prg_cnt == PRG_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      gap_cnt   <= '0;
      prg_cnt   <= '0;
      sweep_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_LOAD;
            gap_cnt <= '0;
          end
        end
        ST_LOAD: begin
          if (accept) begin
            gap_cnt <= '0;
          end else if (tick) begin
            if (gap_cnt == GAP_LAST) begin
              state     <= ST_PROG;
              prg_cnt   <= '0;
              sweep_cnt <= '0;
            end else begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (!sweep_done) sweep_cnt <= sweep_cnt + 1'b1;
          if (tick && prg_cnt != PRG_FULL) prg_cnt <= prg_cnt + 1'b1;
          if (timer_hit && sweep_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sls_secbuf.sv
module sls_secbuf #(
  parameter int OFFS_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clear,
  input  logic [OFFS_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFFS_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_byte
);
  localparam int NBYTES = 1 << OFFS_W;

  logic [DATA_W-1:0] stage [NBYTES];
  logic [NBYTES-1:0] loaded, loaded_nx;

  // A fresh sequence forgets every earlier byte, then marks the one written now.
  always_comb begin
    loaded_nx         = clear ? '0 : loaded;
    loaded_nx[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) loaded <= '0;
    else if (wr_en) loaded <= loaded_nx;
  end

  always_ff @(posedge clk) begin
    if (wr_en) stage[wr_idx] <= wr_data;
  end

  assign rd_byte = loaded[rd_idx] ? stage[rd_idx] : {DATA_W{1'b1}};
endmodule

// File: rtl/sls_array.sv
module sls_array #(
  parameter int AW     = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= {DATA_W{1'b1}};
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/sector_load_seq.sv
module sector_load_seq
  import sector_load_seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int OFFS_W     = 7,
  parameter int DATA_W     = 8,
  parameter int ARR_SECT_W = 3,
  parameter int LOAD_TICKS = 300,
  parameter int PROG_TICKS = 10000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic                         busy,
  output logic [ADDR_W-OFFS_W-1:0]     sector_addr,
  output logic [OFFS_W-1:0]            last_idx,
  output logic                         arr_we,
  output logic [ADDR_W-1:0]            arr_addr,
  output logic [DATA_W-1:0]            arr_wdata,
  input  logic [ARR_SECT_W+OFFS_W-1:0] rd_addr,
  output logic [DATA_W-1:0]            rd_data
);
  localparam int SECT_W  = ADDR_W - OFFS_W;
  localparam int STORE_W = ARR_SECT_W + OFFS_W;

  seq_state_t        state;
  logic              accept, first_wr;
  logic              sweep_we;
  logic [OFFS_W-1:0] sweep_idx;
  logic [SECT_W-1:0] sector_q;
  logic [OFFS_W-1:0] last_q;

  assign wr_ready = (state != ST_PROG);
  assign busy     = (state == ST_PROG);
  assign accept   = wr_valid && wr_ready;
  assign first_wr = accept && (state == ST_IDLE);

  sls_ctrl #(
    .OFFS_W    (OFFS_W),
    .LOAD_TICKS(LOAD_TICKS),
    .PROG_TICKS(PROG_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .accept   (accept),
    .state    (state),
    .sweep_we (sweep_we),
    .sweep_idx(sweep_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sector_q <= '0;
      last_q   <= '0;
    end else begin
      if (first_wr) sector_q <= wr_addr[ADDR_W-1:OFFS_W];
      if (accept)   last_q   <= wr_addr[OFFS_W-1:0];
    end
  end

  assign sector_addr = sector_q;
  assign last_idx    = last_q;

  sls_secbuf #(
    .OFFS_W(OFFS_W),
    .DATA_W(DATA_W)
  ) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (accept),
    .clear  (first_wr),
    .wr_idx (wr_addr[OFFS_W-1:0]),
    .wr_data(wr_data),
    .rd_idx (sweep_idx),
    .rd_byte(arr_wdata)
  );

  assign arr_we   = sweep_we;
  assign arr_addr = {sector_q, sweep_idx};

  sls_array #(
    .AW    (STORE_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (arr_we),
    .waddr(arr_addr[STORE_W-1:0]),
    .wdata(arr_wdata),
    .raddr(rd_addr),
    .rdata(rd_data)
  );
endmodule

// File: rtl/sector_load_seq_chk.sv
module sector_load_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int OFFS_W = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_valid,
  input logic                     wr_ready,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic                     busy,
  input logic [ADDR_W-OFFS_W-1:0] sector_addr,
  input logic [OFFS_W-1:0]        last_idx,
  input logic                     arr_we,
  input logic [ADDR_W-1:0]        arr_addr
);
  localparam int NBYTES = 1 << OFFS_W;

  logic [OFFS_W:0] we_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) we_cnt <= '0;
    else if (arr_we)     we_cnt <= we_cnt + 1'b1;
  end

  p_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  p_we_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  p_we_sector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_addr[ADDR_W-1:OFFS_W] == sector_addr));

  p_we_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      (arr_addr[OFFS_W-1:0] == OFFS_W'($past(arr_addr[OFFS_W-1:0]) + 1'b1)));

  p_sector_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sector_addr));

  p_last_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (last_idx == $past(wr_addr[OFFS_W-1:0])));

  p_full_sweep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (we_cnt == (OFFS_W+1)'(NBYTES)));
endmodule

bind sector_load_seq sector_load_seq_chk #(
  .ADDR_W(ADDR_W),
  .OFFS_W(OFFS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .busy       (busy),
  .sector_addr(sector_addr),
  .last_idx   (last_idx),
  .arr_we     (arr_we),
  .arr_addr   (arr_addr)
);

// File: tb/sector_load_seq_test.sv
module sector_load_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LOAD_T     = 4;
  localparam int PROG_T     = 100;
  localparam int SECT_BITS  = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0;
  logic        wr_valid = 0;
  logic        wr_ready;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy;
  logic [9:0]  sector_addr;
  logic [6:0]  last_idx;
  logic        arr_we;
  logic [16:0] arr_addr;
  logic [7:0]  arr_wdata;
  logic [9:0]  rd_addr = '0;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  int tick_total = 0;
  logic div_ph = 0;

  sector_load_seq #(
    .ARR_SECT_W(SECT_BITS),
    .LOAD_TICKS(LOAD_T),
    .PROG_TICKS(PROG_T)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .sector_addr(sector_addr), .last_idx(last_idx),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tick every second clock, changed away from the active edge
  always @(negedge clk) begin
    div_ph <= ~div_ph;
    tick   <= rst_n && div_ph;
  end
  always @(posedge clk) if (tick) tick_total <= tick_total + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [16:0] mk(input int sec, input int off);
    return {10'(sec), 7'(off)};
  endfunction

  task automatic rd_check(input string tag, input int sec, input int off, input int exp);
    @(negedge clk);
    rd_addr = {3'(sec), 7'(off)};
    #1;
    check(tag, rd_data, exp);
  endtask

  // one accepted write; returns at the negedge after the accepting edge
  task automatic put(input int sec, input int off, input int val);
    @(negedge clk);
    wr_valid = 1; wr_addr = mk(sec, off); wr_data = 8'(val);
    @(negedge clk);
    wr_valid = 0;
    check("R4 last_idx", last_idx, off);
  endtask

  // wait for timeout, then follow the program cycle to its end
  task automatic run_program(input int sec);
    int t0, tb, nb, nwe, bad_sec, bad_rdy;
    t0 = tick_total; nb = 0; nwe = 0; bad_sec = 0; bad_rdy = 0;
    while (!busy) @(negedge clk);
    check("R5 ticks to program start", tick_total - t0, LOAD_T);
    tb = tick_total;
    while (busy) begin
      if (arr_we) begin
        nwe++;
        if (arr_addr[16:7] != 10'(sec)) bad_sec++;
      end
      if (wr_ready) bad_rdy++;
      if (nb == 10) begin
        wr_valid = 1; wr_addr = mk(sec, 1); wr_data = 8'h55;
      end
      if (nb == 13) wr_valid = 0;
      nb++;
      @(negedge clk);
    end
    wr_valid = 0;
    check("R7 ticks in program cycle", tick_total - tb, PROG_T);
    check("R7 ready low while busy", bad_rdy, 0);
    check("R9 array writes per cycle", nwe, 128);
    check("R9 writes in latched sector", bad_sec, 0);
    check("R7 ready back after cycle", wr_ready, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 ready", wr_ready, 1);
    check("R1 arr_we", arr_we, 0);
    rd_check("R1 erased", 3, 0, 8'hFF);
    rd_check("R1 erased", 6, 127, 8'hFF);
  endtask

  task automatic t_load_any_order();
    int t0;
    put(3, 5, 8'h11);
    check("R2 sector latched", sector_addr, 3);
    t0 = tick_total;
    while (tick_total - t0 < LOAD_T - 1) @(negedge clk);
    put(3, 0, 8'hA0);
    check("R5 still loading", busy, 0);
    put(6, 9, 8'h99);
    check("R2 upper bits ignored", sector_addr, 3);
    put(3, 127, 8'h7E);
    put(3, 5, 8'h22);
    run_program(3);
    rd_check("R3 overwritten byte", 3, 5, 8'h22);
    rd_check("R3 byte 0", 3, 0, 8'hA0);
    rd_check("R3 byte 127", 3, 127, 8'h7E);
    rd_check("R2 steered byte", 3, 9, 8'h99);
    rd_check("R2 other sector clean", 6, 9, 8'hFF);
    rd_check("R6 unloaded FF", 3, 50, 8'hFF);
    rd_check("R7 busy write dropped", 3, 1, 8'hFF);
  endtask

  task automatic t_other_sector();
    put(1, 0, 8'h3C);
    check("R2 new sector latched", sector_addr, 1);
    run_program(1);
    rd_check("R6 new byte", 1, 0, 8'h3C);
    rd_check("R6 unloaded FF", 1, 1, 8'hFF);
    rd_check("R8 sector 3 kept", 3, 0, 8'hA0);
  endtask

  task automatic t_reprogram();
    put(3, 7, 8'h5A);
    run_program(3);
    rd_check("R6 old byte erased", 3, 0, 8'hFF);
    rd_check("R6 old byte erased", 3, 5, 8'hFF);
    rd_check("R6 new byte", 3, 7, 8'h5A);
    rd_check("R8 sector 1 kept", 1, 0, 8'h3C);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_load_any_order();
    t_other_sector();
    t_reprogram();
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule